// File: doc/BRIEF.md
# Masked Interrupt Request Arbiter

This block collects a group of level-sensitive interrupt lines from the rest of the chip, brings each through a two-stage synchroniser and holds the result in a pending-status field that follows the line levels. It tells the core that some line is raised at all, before any masking, and separately decides whether an interrupt may actually be taken now.

The decision combines three gates: a per-line enable mask, a global interrupt-enable bit and a debug-mode flag. A line only counts once its mask bit is set. An interrupt is taken only while global enable is high and the core is outside debug mode. When one is taken, the block reports the highest-numbered masked pending line as the one to serve. A wake indication, used to pull an idle core out of its sleep state, looks at the masked pending value only and ignores both the global enable and debug mode.

Top module: `irq_arb`

## Requirements
- R1: Bit n of `pending_o` equals the level that `irq_lines_i[n]` had three rising clock edges earlier: two synchroniser stages, then the pending register.
- R2: `hard_req_o` is 1 exactly when any bit of `pending_o` is 1. The mask, the global enable and debug mode have no effect on it.
- R3: `wake_o` is 1 exactly when `pending_o & irq_en_mask_i` is nonzero. It does not depend on `glob_ie_i` or `debug_mode_i`.
- R4: `take_o` is 1 exactly when `pending_o & irq_en_mask_i` is nonzero, `glob_ie_i` is 1 and `debug_mode_i` is 0.
- R5: While `take_o` is 1, `sel_line_o` is the index of the highest-numbered set bit of `pending_o & irq_en_mask_i`. Line 12 has the highest priority and line 0 the lowest.
- R6: While `take_o` is 0, `sel_line_o` reads 0.
- R7: While `rst_ni` is low, and in the first cycle after it is released, `pending_o` is all zeros. `hard_req_o`, `wake_o`, `take_o` and `sel_line_o` are 0 at the same time.
- R8: A pending line whose mask bit is 0 has no effect on `wake_o`, `take_o` or `sel_line_o`. It still appears in `pending_o` and still drives `hard_req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_lines_i | input | 13 | Raw, asynchronous interrupt lines, level sensitive |
| irq_en_mask_i | input | 13 | Per-line enable mask |
| glob_ie_i | input | 1 | Global interrupt enable |
| debug_mode_i | input | 1 | Core is in debug mode; blocks taking interrupts |
| pending_o | output | 13 | Pending-status field |
| hard_req_o | output | 1 | Some line is pending, before masking |
| wake_o | output | 1 | Masked pending value is nonzero |
| take_o | output | 1 | Interrupt is to be taken now |
| sel_line_o | output | 4 | Selected line number, 0 when `take_o` is low |

## Verification
The first patterns raise single lines, including line 0 and line 12. They show that the selected number tracks the bit position and is not stuck at one end. Multi-line patterns with mixed masks check that a higher raised but unmasked line loses to a lower masked one, which separates mask-aware priority from plain priority. The same pending set is then held while the global enable and debug flag are toggled: `take_o` and `sel_line_o` must fall while `wake_o` and `hard_req_o` stay unchanged. A last pattern drops all lines and checks that the pending field clears again.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int unsigned IRQ_LINES_DEF = 13;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned WIDTH  = 13,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int unsigned WIDTH = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] level_i,
  output logic [WIDTH-1:0] pending_o
);
  // each bit is rewritten every cycle from its own synchronised level
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic pend_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q <= 1'b0;
      else         pend_q <= level_i[b];
    end
    assign pending_o[b] = pend_q;
  end
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int unsigned WIDTH = 13,
  localparam int unsigned IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  // ascending scan: last set bit seen is the highest-numbered one
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/irq_arb.sv
module irq_arb
  import irq_arb_pkg::*;
#(
  parameter int unsigned NUM_LINES   = IRQ_LINES_DEF,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_lines_i,
  input  logic [NUM_LINES-1:0] irq_en_mask_i,
  input  logic                 glob_ie_i,
  input  logic                 debug_mode_i,
  output logic [NUM_LINES-1:0] pending_o,
  output logic                 hard_req_o,
  output logic                 wake_o,
  output logic                 take_o,
  output logic [IDX_W-1:0]     sel_line_o
);
  logic [NUM_LINES-1:0] lines_sync;
  logic [NUM_LINES-1:0] masked;
  logic                 masked_any;
  logic [IDX_W-1:0]     top_idx;
  logic                 gate_open;

  irq_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(irq_lines_i),
    .sync_o (lines_sync)
  );

  irq_pending #(.WIDTH(NUM_LINES)) i_pend (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .level_i  (lines_sync),
    .pending_o(pending_o)
  );

  assign masked = pending_o & irq_en_mask_i;

  irq_prio #(.WIDTH(NUM_LINES)) i_prio (
    .req_i(masked),
    .any_o(masked_any),
    .idx_o(top_idx)
  );

  assign gate_open  = glob_ie_i & ~debug_mode_i;
  assign hard_req_o = |pending_o;
  assign wake_o     = hard_req_o & masked_any;
  assign take_o     = masked_any & gate_open;
  assign sel_line_o = take_o ? top_idx : '0;
endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk #(
  parameter int unsigned NUM_LINES = 13,
  localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_LINES-1:0] irq_lines_i,
  input logic [NUM_LINES-1:0] irq_en_mask_i,
  input logic                 glob_ie_i,
  input logic                 debug_mode_i,
  input logic [NUM_LINES-1:0] pending_o,
  input logic                 hard_req_o,
  input logic                 wake_o,
  input logic                 take_o,
  input logic [IDX_W-1:0]     sel_line_o
);
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  logic [NUM_LINES-1:0] masked_c;
  assign masked_c = pending_o & irq_en_mask_i;

  // R1: three-edge latency from line to pending field
  a_r1_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3) |-> (pending_o == $past(irq_lines_i, 3)));

  // R2
  a_r2_hard_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hard_req_o == (pending_o != '0));

  // R3, R8
  a_r3_wake_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> hard_req_o);

  // R4
  a_r4_take_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (glob_ie_i && !debug_mode_i && wake_o));

  // R5: selected line pending, enabled, and nothing higher
  a_r5_sel_highest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> ((masked_c >> sel_line_o) == NUM_LINES'(1)));

  // R6
  a_r6_sel_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o |-> (sel_line_o == '0));

  // R7
  a_r7_reset_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd0) |-> (pending_o == '0 && !take_o && !wake_o));
endmodule

bind irq_arb irq_arb_chk #(.NUM_LINES(NUM_LINES)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .irq_lines_i  (irq_lines_i),
  .irq_en_mask_i(irq_en_mask_i),
  .glob_ie_i    (glob_ie_i),
  .debug_mode_i (debug_mode_i),
  .pending_o    (pending_o),
  .hard_req_o   (hard_req_o),
  .wake_o       (wake_o),
  .take_o       (take_o),
  .sel_line_o   (sel_line_o)
);

// File: tb/test_irq_arb.sv
`timescale 1ns/1ps
module test_irq_arb;
  localparam int N = 13;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] lines = '0;
  logic [N-1:0] mask = '0;
  logic         ie = 1'b0;
  logic         dbg = 1'b0;
  logic [N-1:0] pend;
  logic         hreq, wake, take;
  logic [3:0]   sel;

  typedef struct {
    logic [N-1:0] pend;
    logic         hreq, wake, take;
    logic [3:0]   sel;
    string        tag;
  } exp_t;

  exp_t sb_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  irq_arb i_irq_arb (
    .clk_i(clk), .rst_ni(rst_n), .irq_lines_i(lines), .irq_en_mask_i(mask),
    .glob_ie_i(ie), .debug_mode_i(dbg), .pending_o(pend), .hard_req_o(hreq),
    .wake_o(wake), .take_o(take), .sel_line_o(sel)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // driver: applies a pattern, waits the pipeline, posts the model result
  task automatic drive(input logic [N-1:0] l, input logic [N-1:0] m,
                       input logic e, input logic d, input string tag);
    exp_t x;
    logic [N-1:0] mp;
    @(negedge clk);
    lines = l; mask = m; ie = e; dbg = d;
    repeat (3) @(posedge clk);
    mp = l & m;
    x.pend = l;
    x.hreq = (l != '0);
    x.wake = (mp != '0);
    x.take = (mp != '0) && e && !d;
    x.sel  = '0;
    if (x.take) for (int i = 0; i < N; i++) if (mp[i]) x.sel = 4'(i);
    x.tag  = tag;
    sb_q.push_back(x);
    wait (sb_q.size() == 0);
  endtask

  // monitor: compares at falling edge, away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() != 0) begin
        exp_t x;
        x = sb_q.pop_front();
        chk({x.tag, " R1 pending"}, pend, x.pend);
        chk({x.tag, " R2 hard_req"}, hreq, x.hreq);
        chk({x.tag, " R3 wake"}, wake, x.wake);
        chk({x.tag, " R4 take"}, take, x.take);
        chk({x.tag, (x.take ? " R5 sel" : " R6 sel")}, sel, x.sel);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R7: held in reset with lines raised
    lines = '1; mask = '1; ie = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R7 pending in reset", pend, 0);
    chk("R7 take in reset", take, 0);
    chk("R7 hard_req in reset", hreq, 0);
    chk("R7 sel in reset", sel, 0);
    lines = '0; mask = '0; ie = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 pending after release", pend, 0);
    chk("R7 wake after release", wake, 0);

    drive(13'h0001, 13'h1FFF, 1, 0, "line0");
    drive(13'h1000, 13'h1FFF, 1, 0, "line12");
    drive(13'h0124, 13'h1FFF, 1, 0, "multi");
    drive(13'h1124, 13'h0FFF, 1, 0, "R8 top masked");
    drive(13'h1124, 13'h0000, 1, 0, "R8 all masked");
    drive(13'h0A50, 13'h0A50, 0, 0, "R4 ie off");
    drive(13'h0A50, 13'h0A50, 1, 1, "R4 debug");
    drive(13'h0A50, 13'h0A50, 0, 1, "R3 both off");
    drive(13'h0A50, 13'h0A50, 1, 0, "R5 reopen");
    drive(13'h1FFF, 13'h0003, 1, 0, "R5 low two");
    drive(13'h0002, 13'h0001, 1, 0, "R8 disjoint");
    drive(13'h0000, 13'h1FFF, 1, 0, "R1 clear");

    // R1: pulse shorter than latency still arrives exactly three edges later
    @(negedge clk);
    lines = 13'h0040; mask = 13'h1FFF; ie = 1'b1; dbg = 1'b0;
    @(negedge clk);
    lines = '0;
    @(negedge clk);
    chk("R1 pulse not yet", pend, 0);
    @(negedge clk);
    chk("R1 pulse seen", pend, 13'h0040);
    chk("R5 pulse sel", sel, 6);
    @(negedge clk);
    chk("R1 pulse gone", pend, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule